// File: doc/BRIEF.md
# Receive Queue with Threshold Interrupt

This block holds incoming serial characters between a receiver and a processor. Each stored entry carries the received byte plus three per-character error marks: a parity mismatch, a missing stop bit, and a break condition. The queue holds up to sixteen entries. The oldest entry is always presented on the read port, and a read strobe removes it.

The block counts how many entries it holds. It compares that count against one of four fixed thresholds chosen by a two-bit selector. When the count reaches the threshold it raises a "data available" interrupt, but only when queue mode and the receive interrupt enable are both on. It also reports whether any entry still held carries an error mark, and whether a character was lost to a full queue. A clear input discards the queue contents in one cycle.

Top module: `rxq_trigger_fifo`

## Requirements
- R1: After `rst` or `clr` the level is 0, and `data_rdy`, `irq`, `err_any` and `overrun` are all 0 from the next cycle. `clr` takes precedence over a write or read in the same cycle.
- R2: Entries leave in the order they arrived. While `data_rdy` is 1, `rd_data`, `rd_perr`, `rd_ferr` and `rd_brk` show the oldest entry, and an `rd_en` pulse removes it at the clock edge.
- R3: A write while the level is 16 and no read is taken in the same cycle is dropped. The level stays at 16 and `overrun` becomes 1. The level never exceeds 16.
- R4: `overrun` stays 1 until a cycle with `stat_rd` high clears it. If a new dropped write falls in that same cycle, `overrun` stays 1.
- R5: `trig_sel` selects the interrupt threshold: 0 gives 1 entry, 1 gives 4, 2 gives 8 and 3 gives 14. `irq` is 1 in the cycle after the write that brings the level up to the threshold.
- R6: `irq` is 0 unless `fifo_on` and `rx_int_en` are both 1.
- R7: `irq` stays 1 while later writes continue to fill the queue up to 16 entries. It falls in the cycle after the read that brings the level below the threshold.
- R8: `err_any` is 1 exactly while at least one held entry has any of its three error marks set. It returns to 0 once the last marked entry has been read out.
- R9: `data_rdy` is 1 exactly while the level is at least 1.
- R10: A read and a write in the same cycle on a non-empty queue both take effect and leave the level unchanged. This also applies when the queue is full, in which case the write is accepted.
- R11: A read strobe on an empty queue has no effect. The level stays 0, and a write in the same cycle is still stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous queue clear |
| fifo_on | input | 1 | Queue mode enable, gates the interrupt |
| rx_int_en | input | 1 | Receive interrupt enable |
| trig_sel | input | 2 | Threshold selector (0:1, 1:4, 2:8, 3:14) |
| wr_en | input | 1 | Receiver write strobe |
| wr_data | input | 8 | Received byte |
| wr_perr | input | 1 | Parity error mark of the byte |
| wr_ferr | input | 1 | Framing error mark of the byte |
| wr_brk | input | 1 | Break mark of the byte |
| rd_en | input | 1 | Processor read strobe, removes the oldest entry |
| stat_rd | input | 1 | Status read, clears the overrun flag |
| rd_data | output | 8 | Oldest byte |
| rd_perr | output | 1 | Parity mark of the oldest entry |
| rd_ferr | output | 1 | Framing mark of the oldest entry |
| rd_brk | output | 1 | Break mark of the oldest entry |
| level | output | 5 | Number of entries held |
| data_rdy | output | 1 | At least one entry held |
| err_any | output | 1 | Some held entry carries an error mark |
| overrun | output | 1 | Sticky lost-character flag |
| irq | output | 1 | Data-available interrupt |

## Verification
The two functions that collide are the receiver push and the processor pop. Both can fall in one cycle, including at the full boundary, where the push must be accepted instead of dropped. The bench provokes this directly on a full queue and repeatedly in random traffic. It judges each cycle against a queue model kept in the bench, checking the level, the head entry, the error summary and the overrun flag. A second collision between a dropped write and a status read is also driven, and the overrun flag must stay set.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    localparam int RXQ_DW = 8;

    typedef struct packed {
        logic              brk;
        logic              ferr;
        logic              perr;
        logic [RXQ_DW-1:0] data;
    } rxq_entry_t;

    typedef enum logic [1:0] {
        TRIG_ONE      = 2'd0,
        TRIG_FOUR     = 2'd1,
        TRIG_EIGHT    = 2'd2,
        TRIG_FOURTEEN = 2'd3
    } rxq_trig_e;

    function automatic logic entry_flagged(input rxq_entry_t e);
        return e.brk | e.ferr | e.perr;
    endfunction

    function automatic int unsigned trig_depth(input rxq_trig_e sel);
        case (sel)
            TRIG_ONE:   return 1;
            TRIG_FOUR:  return 4;
            TRIG_EIGHT: return 8;
            default:    return 14;
        endcase
    endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       push,
    input  logic       pop,
    input  rxq_entry_t wr_ent,
    output rxq_entry_t head_ent
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    rxq_entry_t        mem [DEPTH];
    logic [AW-1:0]     wptr, rptr;
    logic [AW-1:0]     wptr_nx, rptr_nx;

    generate
        if ((1 << AW) == DEPTH) begin : g_pow2
            assign wptr_nx = wptr + AW'(1);
            assign rptr_nx = rptr + AW'(1);
        end else begin : g_wrap
            assign wptr_nx = (wptr == AW'(DEPTH-1)) ? '0 : wptr + AW'(1);
            assign rptr_nx = (rptr == AW'(DEPTH-1)) ? '0 : rptr + AW'(1);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (push) mem[wptr] <= wr_ent;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wptr <= '0;
            rptr <= '0;
        end else begin
            if (push) wptr <= wptr_nx;
            if (pop)  rptr <= rptr_nx;
        end
    end

    assign head_ent = mem[rptr];

endmodule

// File: rtl/rxq_track.sv
module rxq_track #(
    parameter int DEPTH = 16,
    parameter int CW    = $clog2(DEPTH+1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic          stat_rd,
    input  logic          wr_flag,
    input  logic          head_flag,
    output logic          push,
    output logic          pop,
    output logic [CW-1:0] level,
    output logic          err_any,
    output logic          overrun
);
    logic          full, empty, drop;
    logic [CW-1:0] err_cnt;

    assign full  = (level == CW'(DEPTH));
    assign empty = (level == '0);
    assign pop   = rd_en & ~empty & ~clr;
    assign push  = wr_en & (~full | pop) & ~clr;
    assign drop  = wr_en & full & ~pop & ~clr;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            level   <= '0;
            err_cnt <= '0;
        end else begin
            level   <= level + CW'(push) - CW'(pop);
            err_cnt <= err_cnt + CW'(push & wr_flag) - CW'(pop & head_flag);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr)   overrun <= 1'b0;
        else if (drop)    overrun <= 1'b1;
        else if (stat_rd) overrun <= 1'b0;
    end

    assign err_any = (err_cnt != '0);

endmodule

// File: rtl/rxq_trigger.sv
module rxq_trigger
    import rxq_pkg::*;
#(
    parameter int CW = 5
) (
    input  logic          fifo_on,
    input  logic          rx_int_en,
    input  rxq_trig_e     sel,
    input  logic [CW-1:0] level,
    output logic          irq
);
    logic reached;

    always_comb begin
        reached = (int'(level) >= int'(trig_depth(sel)));
        irq     = fifo_on & rx_int_en & reached;
    end

endmodule

// File: rtl/rxq_trigger_fifo.sv
module rxq_trigger_fifo
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         clr,
    input  logic                         fifo_on,
    input  logic                         rx_int_en,
    input  logic [1:0]                   trig_sel,
    input  logic                         wr_en,
    input  logic [7:0]                   wr_data,
    input  logic                         wr_perr,
    input  logic                         wr_ferr,
    input  logic                         wr_brk,
    input  logic                         rd_en,
    input  logic                         stat_rd,
    output logic [7:0]                   rd_data,
    output logic                         rd_perr,
    output logic                         rd_ferr,
    output logic                         rd_brk,
    output logic [$clog2(DEPTH+1)-1:0]   level,
    output logic                         data_rdy,
    output logic                         err_any,
    output logic                         overrun,
    output logic                         irq
);
    localparam int CW = $clog2(DEPTH+1);

    rxq_entry_t wr_ent, head_ent;
    logic       push, pop;

    assign wr_ent = '{brk: wr_brk, ferr: wr_ferr, perr: wr_perr, data: wr_data};

    rxq_store #(.DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst      (rst),
        .clr      (clr),
        .push     (push),
        .pop      (pop),
        .wr_ent   (wr_ent),
        .head_ent (head_ent)
    );

    rxq_track #(.DEPTH(DEPTH), .CW(CW)) u_track (
        .clk       (clk),
        .rst       (rst),
        .clr       (clr),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .stat_rd   (stat_rd),
        .wr_flag   (entry_flagged(wr_ent)),
        .head_flag (entry_flagged(head_ent)),
        .push      (push),
        .pop       (pop),
        .level     (level),
        .err_any   (err_any),
        .overrun   (overrun)
    );

    rxq_trigger #(.CW(CW)) u_trig (
        .fifo_on   (fifo_on),
        .rx_int_en (rx_int_en),
        .sel       (rxq_trig_e'(trig_sel)),
        .level     (level),
        .irq       (irq)
    );

    assign rd_data  = head_ent.data;
    assign rd_perr  = head_ent.perr;
    assign rd_ferr  = head_ent.ferr;
    assign rd_brk   = head_ent.brk;
    assign data_rdy = (level != '0);

endmodule

// File: rtl/rxq_checker.sv
module rxq_checker #(
    parameter int DEPTH = 16,
    parameter int CW    = $clog2(DEPTH+1)
) (
    input logic          clk,
    input logic          rst,
    input logic          clr,
    input logic          fifo_on,
    input logic          rx_int_en,
    input logic          wr_en,
    input logic          rd_en,
    input logic          stat_rd,
    input logic [CW-1:0] level,
    input logic          data_rdy,
    input logic          err_any,
    input logic          overrun,
    input logic          irq
);
    logic is_full;
    assign is_full = (level == CW'(DEPTH));

    p_cap_r3: assert property (@(posedge clk) disable iff (rst)
        int'(level) <= DEPTH);

    p_drop_r3: assert property (@(posedge clk) disable iff (rst)
        (is_full && wr_en && !rd_en && !clr) |=> (is_full && overrun));

    p_clear_r1: assert property (@(posedge clk) disable iff (rst)
        clr |=> (level == '0 && !err_any && !overrun && !data_rdy));

    p_keep_orun_r4: assert property (@(posedge clk) disable iff (rst)
        (overrun && !stat_rd && !clr) |=> overrun);

    p_gate_r6: assert property (@(posedge clk) disable iff (rst)
        !(fifo_on && rx_int_en) |-> !irq);

    p_ready_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !clr) |=> data_rdy);

    p_both_r10: assert property (@(posedge clk) disable iff (rst)
        (wr_en && rd_en && data_rdy && !clr) |=> (level == $past(level)));

    p_empty_rd_r11: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !wr_en && !data_rdy && !clr) |=> (level == '0));

endmodule

bind rxq_trigger_fifo rxq_checker #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .clr       (clr),
    .fifo_on   (fifo_on),
    .rx_int_en (rx_int_en),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .stat_rd   (stat_rd),
    .level     (level),
    .data_rdy  (data_rdy),
    .err_any   (err_any),
    .overrun   (overrun),
    .irq       (irq)
);

// File: tb/tb_rxq_trigger_fifo.sv
`timescale 1ns/1ps
module tb_rxq_trigger_fifo;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       clr = 1'b0;
    logic       fifo_on = 1'b1;
    logic       rx_int_en = 1'b1;
    logic [1:0] trig_sel = 2'd3;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       wr_perr = 1'b0, wr_ferr = 1'b0, wr_brk = 1'b0;
    logic       rd_en = 1'b0;
    logic       stat_rd = 1'b0;
    logic [7:0] rd_data;
    logic       rd_perr, rd_ferr, rd_brk;
    logic [4:0] level;
    logic       data_rdy, err_any, overrun, irq;

    int checks = 0;
    int errors = 0;

    logic [10:0] mq[$];
    bit          morun = 0;

    always #2.5 clk = ~clk;

    rxq_trigger_fifo dut (
        .clk(clk), .rst(rst), .clr(clr), .fifo_on(fifo_on), .rx_int_en(rx_int_en),
        .trig_sel(trig_sel), .wr_en(wr_en), .wr_data(wr_data), .wr_perr(wr_perr),
        .wr_ferr(wr_ferr), .wr_brk(wr_brk), .rd_en(rd_en), .stat_rd(stat_rd),
        .rd_data(rd_data), .rd_perr(rd_perr), .rd_ferr(rd_ferr), .rd_brk(rd_brk),
        .level(level), .data_rdy(data_rdy), .err_any(err_any), .overrun(overrun),
        .irq(irq)
    );

    function automatic int tb_trig(input logic [1:0] s);
        case (s)
            2'd0: return 1;
            2'd1: return 4;
            2'd2: return 8;
            default: return 14;
        endcase
    endfunction

    function automatic bit model_err();
        foreach (mq[i]) if (mq[i][10:8] != 3'b000) return 1;
        return 0;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        int  n = mq.size();
        bit  ei = fifo_on && rx_int_en && (n >= tb_trig(trig_sel));
        chk(int'(level) == n, "R3 level", int'(level), n);
        chk(data_rdy == (n > 0), "R9 data_rdy", data_rdy, n > 0);
        chk(irq == ei, "R5 irq", irq, ei);
        chk(err_any == model_err(), "R8 err_any", err_any, model_err());
        chk(overrun == morun, "R4 overrun", overrun, morun);
        if (n > 0)
            chk({rd_brk, rd_ferr, rd_perr, rd_data} == mq[0], "R2 head",
                {rd_brk, rd_ferr, rd_perr, rd_data}, mq[0]);
    endtask

    task automatic cyc(input bit w, input logic [10:0] wd, input bit r,
                       input bit sr, input bit c);
        bit popd, pushd, ovf;
        @(negedge clk);
        wr_en = w; {wr_brk, wr_ferr, wr_perr, wr_data} = wd;
        rd_en = r; stat_rd = sr; clr = c;
        @(posedge clk);
        if (c) begin
            mq.delete();
            morun = 0;
        end else begin
            popd  = r && mq.size() > 0;
            pushd = w && (mq.size() < 16 || popd);
            ovf   = w && mq.size() == 16 && !popd;
            if (popd)  void'(mq.pop_front());
            if (pushd) mq.push_back(wd);
            if (ovf)       morun = 1;
            else if (sr)   morun = 0;
        end
        #1;
        compare_all();
    endtask

    initial begin
        #1000000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [10:0] h;
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        @(posedge clk); #1;
        // R1: reset state
        chk(level == 0 && !data_rdy && !irq && !err_any && !overrun, "R1 reset", level, 0);

        // fill with threshold 14
        trig_sel = 2'd3;
        for (int i = 0; i < 13; i++) cyc(1, 11'(i + 8'h40), 0, 0, 0);
        chk(irq == 1'b0, "R5 below 14", irq, 0);
        cyc(1, 11'h04D, 0, 0, 0);
        chk(irq == 1'b1, "R5 at 14", irq, 1);
        cyc(1, 11'h04E, 0, 0, 0);
        cyc(1, 11'h04F, 0, 0, 0);
        chk(irq == 1'b1 && level == 16, "R7 still high at 16", level, 16);
        cyc(1, 11'h0AA, 0, 0, 0);
        chk(level == 16 && overrun, "R3 dropped write", level, 16);
        // dropped write coincident with status read keeps flag
        cyc(1, 11'h0AB, 0, 1, 0);
        chk(overrun == 1'b1, "R4 set wins over clear", overrun, 1);
        cyc(0, 0, 0, 1, 0);
        chk(overrun == 1'b0, "R4 cleared by status read", overrun, 0);
        // R10: read and write together when full
        h = mq[1];
        cyc(1, 11'h0C3, 1, 0, 0);
        chk(level == 16 && {rd_brk, rd_ferr, rd_perr, rd_data} == h, "R10 full rd+wr", level, 16);
        cyc(0, 0, 1, 0, 0);
        cyc(0, 0, 1, 0, 0);
        chk(irq == 1'b1, "R7 at 14 after reads", irq, 1);
        cyc(0, 0, 1, 0, 0);
        chk(irq == 1'b0 && level == 13, "R7 below trigger", irq, 0);
        // R6 gating
        trig_sel = 2'd0;
        fifo_on = 1'b0;
        cyc(0, 0, 0, 0, 0);
        chk(irq == 1'b0, "R6 queue mode off", irq, 0);
        fifo_on = 1'b1; rx_int_en = 1'b0;
        cyc(0, 0, 0, 0, 0);
        chk(irq == 1'b0, "R6 interrupt enable off", irq, 0);
        rx_int_en = 1'b1;
        cyc(0, 0, 0, 0, 0);
        chk(irq == 1'b1, "R6 both on", irq, 1);
        // R1 clear with pending write
        cyc(1, 11'h011, 1, 0, 1);
        chk(level == 0 && !data_rdy && !err_any, "R1 clear", level, 0);
        // R11: read of empty
        cyc(0, 0, 1, 0, 0);
        chk(level == 0, "R11 empty read", level, 0);
        cyc(1, 11'h05A, 1, 0, 0);
        chk(level == 1 && rd_data == 8'h5A, "R11 empty read with write", level, 1);
        // R8 error summary
        cyc(1, 11'h200, 0, 0, 0);
        cyc(1, 11'h033, 0, 0, 0);
        chk(err_any == 1'b1, "R8 marked entry held", err_any, 1);
        cyc(0, 0, 1, 0, 0);
        chk(err_any == 1'b1, "R8 still held", err_any, 1);
        cyc(0, 0, 1, 0, 0);
        chk(err_any == 1'b0, "R8 last marked popped", err_any, 0);
        // R5 each threshold
        for (int s = 0; s < 4; s++) begin
            trig_sel = 2'(s);
            cyc(0, 0, 0, 0, 1);
            for (int k = 0; k < tb_trig(2'(s)) - 1; k++) cyc(1, 11'(k), 0, 0, 0);
            chk(irq == 1'b0, "R5 one below", irq, 0);
            cyc(1, 11'h07F, 0, 0, 0);
            chk(irq == 1'b1, "R5 reached", irq, 1);
        end
        // random traffic
        for (int i = 0; i < 4000; i++) begin
            logic [10:0] d;
            d[7:0] = 8'($urandom);
            d[8]   = ($urandom % 10) == 0;
            d[9]   = ($urandom % 12) == 0;
            d[10]  = ($urandom % 15) == 0;
            if (($urandom % 50) == 0) trig_sel = 2'($urandom);
            fifo_on   = ($urandom % 8) != 0;
            rx_int_en = ($urandom % 8) != 0;
            cyc(($urandom % 100) < 55, d, ($urandom % 100) < 45,
                ($urandom % 10) == 0, ($urandom % 60) == 0);
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule